// File: doc/BRIEF.md
# Triggered Segment Streaming Controller

This block sits in a sample path between a source that presents one sample per valid cycle and a downstream host-transfer path. It decides which samples pass and groups the passed samples into segments. Each forwarded sample comes out one clock after it was presented. The first sample of a segment carries a start marker and the last one carries an end marker. Samples that fall outside a segment are dropped.

Three modes set how a trigger strobe opens and closes a segment. In infinite mode, one trigger opens a single segment that only a stop request ends. In fixed mode, each trigger opens a segment of a programmed number of samples. In variable mode, triggers alternate between opening and closing a segment, and a closing trigger counts only once a minimum number of samples has been captured.

At every segment end the block reports the number of samples actually captured and advances a segment counter. A finite segment budget can be set, or lifted with a flag. In fixed mode, triggers that arrive during a segment are tallied as missed.

Top module: `seg_stream_ctrl`

## Requirements
- R1: After reset, out_valid, out_sos and out_eos are 0, and seg_count, seg_len and missed_count are 0.
- R2: With cfg_mode=0 (infinite; code 3 behaves the same), a trigger opens a segment. Every valid sample from then on is forwarded one cycle later with its data. Only a stop ends the segment. out_sos marks the first forwarded sample.
- R3: With cfg_mode=1 (fixed), a trigger opens a segment of exactly cfg_seg_len valid samples, with a value of 0 or 1 giving one sample. out_eos marks the last sample, and valid samples between segments are not forwarded.
- R4: With cfg_mode=1, a trigger that arrives while a segment is open has no effect on the segment and raises missed_count by 1. missed_count saturates at its maximum.
- R5: With cfg_mode=2 (variable), a trigger in idle opens a segment. The next trigger that arrives once at least cfg_min_len samples have been forwarded closes it. The last sample is the valid sample of that trigger cycle, or the next valid sample if that cycle had none.
- R6: With cfg_mode=2, a trigger that arrives while fewer than cfg_min_len samples have been forwarded is ignored, and the segment continues.
- R7: A stop while a segment is open makes the next valid sample, including one in the same cycle, the last sample, marked with out_eos. The block then goes idle. A stop while idle has no effect, and it blocks a trigger in the same cycle.
- R8: In the cycle out_eos is 1, seg_len holds the number of samples in that segment and seg_count has risen by 1. seg_len holds this value until the next end.
- R9: When cfg_inf_num is 0 and seg_count equals cfg_num_seg, triggers in idle open no segment. cfg_inf_num=1 lifts this limit.
- R10: With cfg_mode=1 and cfg_inf_len=1, a segment never ends by length and only a stop ends it.
- R11: The valid sample presented in the cycle of the opening trigger is the first sample of the segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_data | input | DATA_W | Input sample |
| trig | input | 1 | Single-cycle trigger strobe |
| stop | input | 1 | Software stop request |
| cfg_mode | input | 2 | 0 infinite, 1 fixed, 2 variable, 3 infinite |
| cfg_seg_len | input | LEN_W | Fixed segment length in samples |
| cfg_inf_len | input | 1 | Ignore cfg_seg_len in fixed mode |
| cfg_num_seg | input | CNT_W | Segment budget |
| cfg_inf_num | input | 1 | No segment budget |
| cfg_min_len | input | LEN_W | Minimum samples before a closing trigger counts |
| out_valid | output | 1 | Forwarded sample present |
| out_data | output | DATA_W | Forwarded sample |
| out_sos | output | 1 | First sample of segment |
| out_eos | output | 1 | Last sample of segment |
| seg_count | output | CNT_W | Segments closed since reset |
| seg_len | output | LEN_W | Sample count of the last closed segment |
| missed_count | output | MISS_W | Fixed-mode triggers that arrived during a segment |

## Verification
The bench places triggers on the segment boundaries. One is an early closing trigger in variable mode, which a design with a wrong length compare would accept, producing a short segment. One is a trigger during a fixed segment, which a wrong design would let restart the length or leave uncounted. A closing trigger or stop in a cycle without a sample must still end the segment on the next sample; a design that dropped the pending request would run on. The bench also checks that a stop and a trigger together while idle open nothing, and that the segment budget blocks exactly one trigger past its limit; off-by-one budget logic would open one segment too many.

// File: rtl/seg_stream_pkg.sv
// Shared types for the segment streaming controller.
// Assumes: mode code 3 is treated as infinite mode.
package seg_stream_pkg;
    typedef enum logic [1:0] {
        MODE_INF   = 2'd0,
        MODE_FIXED = 2'd1,
        MODE_VAR   = 2'd2,
        MODE_INF2  = 2'd3
    } seg_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } seg_state_e;
endpackage

// File: rtl/seg_ctrl_fsm.sv
// Segment sequencer: decides per cycle whether the sample passes and whether
// it opens or closes a segment. Assumes len_i counts samples forwarded so far
// in the open segment and is zero between segments.
module seg_ctrl_fsm
    import seg_stream_pkg::*;
#(
    parameter int LEN_W = 64,
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             trig,
    input  logic             stop,
    input  logic [1:0]       cfg_mode,
    input  logic [LEN_W-1:0] cfg_seg_len,
    input  logic             cfg_inf_len,
    input  logic [CNT_W-1:0] cfg_num_seg,
    input  logic             cfg_inf_num,
    input  logic [LEN_W-1:0] cfg_min_len,
    input  logic [LEN_W-1:0] len_i,
    input  logic [CNT_W-1:0] seg_count_i,
    output logic             fwd_o,
    output logic             first_o,
    output logic             last_o,
    output logic             miss_o
);
    seg_state_e state_q, state_d;
    logic       pend_q, pend_d;
    seg_mode_e  mode;
    logic       active, quota_ok, open_now, seg_on;
    logic       close_trig, end_req, len_hit;

    // Decode the mode and the open/close conditions for this cycle.
    always_comb begin
        mode       = seg_mode_e'(cfg_mode);
        active     = (state_q == ST_ACTIVE);
        quota_ok   = cfg_inf_num || (seg_count_i < cfg_num_seg);
        open_now   = !active && trig && !stop && quota_ok;
        seg_on     = active || open_now;
        close_trig = active && trig && (mode == MODE_VAR) && (len_i >= cfg_min_len);
        end_req    = pend_q || (active && stop) || close_trig;
        len_hit    = (mode == MODE_FIXED) && !cfg_inf_len &&
                     ((len_i + {{(LEN_W-1){1'b0}}, 1'b1}) >= cfg_seg_len);
        fwd_o      = seg_on && in_valid;
        first_o    = fwd_o && (len_i == '0);
        last_o     = fwd_o && (end_req || len_hit);
        miss_o     = active && trig && (mode == MODE_FIXED);
    end

    // Next state and pending-close flag.
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        if (last_o) begin
            state_d = ST_IDLE;
            pend_d  = 1'b0;
        end else begin
            if (open_now) state_d = ST_ACTIVE;
            if (seg_on && end_req) pend_d = 1'b1;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // A pending close only exists inside an open segment.
    assert_pend_in_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> (state_q == ST_ACTIVE));
    // A sample closing a segment is always a forwarded one.
    assert_last_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> fwd_o);
endmodule

// File: rtl/seg_len_track.sv
// Per-segment sample counter and end-of-segment length report.
// Assumes fwd_i/last_i come from the sequencer in the same cycle.
module seg_len_track #(
    parameter int LEN_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_i,
    input  logic             last_i,
    output logic [LEN_W-1:0] len_o,
    output logic [LEN_W-1:0] seg_len_o
);
    logic [LEN_W-1:0] len_q, rep_q;
    logic             done_q;

    // Count forwarded samples; latch the total at the closing sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            rep_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_i;
            if (last_i) begin
                len_q <= '0;
                rep_q <= len_q + {{(LEN_W-1){1'b0}}, 1'b1};
            end else if (fwd_i) begin
                len_q <= len_q + {{(LEN_W-1){1'b0}}, 1'b1};
            end
        end
    end

    assign len_o     = len_q;
    assign seg_len_o = rep_q;

    // A reported segment is never empty.
    assert_len_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (rep_q != '0));
endmodule

// File: rtl/seg_count_track.sv
// Closed-segment counter and missed-trigger counter, both saturating.
module seg_count_track #(
    parameter int CNT_W  = 26,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              last_i,
    input  logic              miss_i,
    output logic [CNT_W-1:0]  seg_count_o,
    output logic [MISS_W-1:0] missed_o
);
    logic [CNT_W-1:0]  cnt_q;
    logic [MISS_W-1:0] miss_q;

    // Advance the counters on segment close and on a missed trigger.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            miss_q <= '0;
        end else begin
            if (last_i && (cnt_q != '1)) cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
            if (miss_i && (miss_q != '1)) miss_q <= miss_q + {{(MISS_W-1){1'b0}}, 1'b1};
        end
    end

    assign seg_count_o = cnt_q;
    assign missed_o    = miss_q;

    // The segment count moves only after a closing sample.
    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> $past(last_i));
    // The missed count moves only after a missed trigger.
    assert_miss_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_q != $past(miss_q)) |-> $past(miss_i));
endmodule

// File: rtl/seg_stream_ctrl.sv
// Top of the triggered segment streaming controller. Registers the gated
// sample stream with start/end markers one cycle after the input sample.
// Assumes configuration stays stable while a segment is open.
module seg_stream_ctrl #(
    parameter int DATA_W = 12,
    parameter int LEN_W  = 64,
    parameter int CNT_W  = 26,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              trig,
    input  logic              stop,
    input  logic [1:0]        cfg_mode,
    input  logic [LEN_W-1:0]  cfg_seg_len,
    input  logic              cfg_inf_len,
    input  logic [CNT_W-1:0]  cfg_num_seg,
    input  logic              cfg_inf_num,
    input  logic [LEN_W-1:0]  cfg_min_len,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sos,
    output logic              out_eos,
    output logic [CNT_W-1:0]  seg_count,
    output logic [LEN_W-1:0]  seg_len,
    output logic [MISS_W-1:0] missed_count
);
    logic             fwd, first, last, miss;
    logic [LEN_W-1:0] len_cur;

    seg_ctrl_fsm #(.LEN_W(LEN_W), .CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .trig(trig), .stop(stop),
        .cfg_mode(cfg_mode), .cfg_seg_len(cfg_seg_len), .cfg_inf_len(cfg_inf_len),
        .cfg_num_seg(cfg_num_seg), .cfg_inf_num(cfg_inf_num), .cfg_min_len(cfg_min_len),
        .len_i(len_cur), .seg_count_i(seg_count),
        .fwd_o(fwd), .first_o(first), .last_o(last), .miss_o(miss)
    );

    seg_len_track #(.LEN_W(LEN_W)) len_i (
        .clk(clk), .rst_n(rst_n), .fwd_i(fwd), .last_i(last),
        .len_o(len_cur), .seg_len_o(seg_len)
    );

    seg_count_track #(.CNT_W(CNT_W), .MISS_W(MISS_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .last_i(last), .miss_i(miss),
        .seg_count_o(seg_count), .missed_o(missed_count)
    );

    // Output stage: one register on the gated sample and its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sos   <= 1'b0;
            out_eos   <= 1'b0;
        end else begin
            out_valid <= fwd;
            out_sos   <= first;
            out_eos   <= last;
            if (fwd) out_data <= in_data;
        end
    end

    // Markers always ride on a forwarded sample.
    assert_sos_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_sos |-> out_valid);
    assert_eos_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_eos |-> out_valid);
    // The segment count advances together with the end marker.
    assert_eos_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_eos |-> (seg_count != $past(seg_count)));
endmodule

// File: tb/seg_stream_ctrl_tb_top.sv
// Directed bench for seg_stream_ctrl: one task per scenario.
module seg_stream_ctrl_tb_top;
    localparam int DW = 12, LW = 64, CW = 26, MW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          trig = 1'b0, stop = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [LW-1:0] cfg_seg_len = '0, cfg_min_len = '0;
    logic          cfg_inf_len = 1'b0, cfg_inf_num = 1'b1;
    logic [CW-1:0] cfg_num_seg = '0;
    logic          out_valid, out_sos, out_eos;
    logic [DW-1:0] out_data;
    logic [CW-1:0] seg_count;
    logic [LW-1:0] seg_len;
    logic [MW-1:0] missed_count;

    int checks = 0, errors = 0;
    int exp_cnt = 0;
    int exp_miss = 0;

    seg_stream_ctrl #(.DATA_W(DW), .LEN_W(LW), .CNT_W(CW), .MISS_W(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .trig(trig), .stop(stop), .cfg_mode(cfg_mode), .cfg_seg_len(cfg_seg_len),
        .cfg_inf_len(cfg_inf_len), .cfg_num_seg(cfg_num_seg), .cfg_inf_num(cfg_inf_num),
        .cfg_min_len(cfg_min_len), .out_valid(out_valid), .out_data(out_data),
        .out_sos(out_sos), .out_eos(out_eos), .seg_count(seg_count),
        .seg_len(seg_len), .missed_count(missed_count)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then check the registered result.
    task automatic cyc(input logic v, input int d, input logic t, input logic s,
                       input logic ev, input logic es, input logic ee, input string tag);
        @(negedge clk);
        in_valid = v; in_data = DW'(d); trig = t; stop = s;
        @(posedge clk);
        #2;
        in_valid = 1'b0; trig = 1'b0; stop = 1'b0;
        chk({tag, " valid"}, longint'(out_valid), longint'(ev));
        chk({tag, " sos"}, longint'(out_sos), longint'(es));
        chk({tag, " eos"}, longint'(out_eos), longint'(ee));
        if (ev) chk({tag, " data"}, longint'(out_data), longint'(d));
    endtask

    task automatic seg_end_chk(input string tag, input longint len);
        exp_cnt++;
        chk({tag, " seg_len"}, longint'(seg_len), len);
        chk({tag, " seg_count"}, longint'(seg_count), longint'(exp_cnt));
    endtask

    task automatic t_reset;
        chk("R1 out_valid", longint'(out_valid), 0);
        chk("R1 out_sos", longint'(out_sos), 0);
        chk("R1 out_eos", longint'(out_eos), 0);
        chk("R1 seg_count", longint'(seg_count), 0);
        chk("R1 seg_len", longint'(seg_len), 0);
        chk("R1 missed", longint'(missed_count), 0);
    endtask

    task automatic t_infinite;
        cfg_mode = 2'd0;
        cyc(1, 5, 0, 0, 0, 0, 0, "R2 idle drop");
        cyc(1, 10, 1, 0, 1, 1, 0, "R11 trigger sample first");
        cyc(0, 0, 0, 0, 0, 0, 0, "R2 gap");
        cyc(1, 11, 0, 0, 1, 0, 0, "R2 fwd");
        cyc(1, 12, 1, 0, 1, 0, 0, "R2 retrigger ignored");
        cyc(1, 13, 0, 1, 1, 0, 1, "R7 stop same cycle");
        seg_end_chk("R8 inf", 4);
        cyc(1, 14, 0, 0, 0, 0, 0, "R7 idle after stop");
    endtask

    task automatic t_fixed;
        cfg_mode = 2'd1; cfg_seg_len = 3;
        cyc(1, 20, 1, 0, 1, 1, 0, "R3 open");
        cyc(1, 21, 1, 0, 1, 0, 0, "R4 trig in segment");
        exp_miss++;
        chk("R4 missed", longint'(missed_count), longint'(exp_miss));
        cyc(0, 0, 0, 0, 0, 0, 0, "R3 no sample");
        cyc(1, 22, 0, 0, 1, 0, 1, "R3 last");
        seg_end_chk("R8 fixed", 3);
        cyc(1, 23, 0, 0, 0, 0, 0, "R3 gap drop");
        chk("R4 missed stays", longint'(missed_count), longint'(exp_miss));
    endtask

    task automatic t_variable;
        cfg_mode = 2'd2; cfg_min_len = 4;
        cyc(1, 30, 1, 0, 1, 1, 0, "R5 open");
        cyc(1, 31, 0, 0, 1, 0, 0, "R5 s2");
        cyc(1, 32, 1, 0, 1, 0, 0, "R6 early close ignored");
        cyc(1, 33, 0, 0, 1, 0, 0, "R6 s4");
        cyc(1, 34, 1, 0, 1, 0, 1, "R5 close");
        seg_end_chk("R8 var", 5);
        cyc(1, 35, 0, 0, 0, 0, 0, "R5 gap drop");
        cyc(1, 40, 1, 0, 1, 1, 0, "R5 open2");
        cyc(1, 41, 0, 0, 1, 0, 0, "R5 b2");
        cyc(1, 42, 0, 0, 1, 0, 0, "R5 b3");
        cyc(1, 43, 0, 0, 1, 0, 0, "R5 b4");
        cyc(0, 0, 1, 0, 0, 0, 0, "R5 close no sample");
        cyc(1, 44, 0, 0, 1, 0, 1, "R5 pending close");
        seg_end_chk("R8 var2", 5);
        chk("R4 no miss in var", longint'(missed_count), longint'(exp_miss));
    endtask

    task automatic t_stop;
        cfg_mode = 2'd1; cfg_seg_len = 10;
        cyc(1, 50, 1, 0, 1, 1, 0, "R7 open");
        cyc(1, 51, 0, 0, 1, 0, 0, "R7 s2");
        cyc(0, 0, 0, 1, 0, 0, 0, "R7 stop no sample");
        cyc(0, 0, 0, 0, 0, 0, 0, "R7 wait");
        cyc(1, 52, 0, 0, 1, 0, 1, "R7 end on next");
        seg_end_chk("R8 stop", 3);
        cyc(1, 53, 1, 1, 0, 0, 0, "R7 stop blocks trig");
        cyc(1, 54, 0, 0, 0, 0, 0, "R7 still idle");
        chk("R7 count unchanged", longint'(seg_count), longint'(exp_cnt));
    endtask

    task automatic t_quota;
        cfg_mode = 2'd1; cfg_seg_len = 2;
        cfg_inf_num = 1'b0; cfg_num_seg = CW'(exp_cnt + 1);
        cyc(1, 60, 1, 0, 1, 1, 0, "R9 last allowed");
        cyc(1, 61, 0, 0, 1, 0, 1, "R9 end");
        seg_end_chk("R9 seg", 2);
        cyc(1, 62, 1, 0, 0, 0, 0, "R9 budget blocks");
        cyc(1, 63, 0, 0, 0, 0, 0, "R9 stays idle");
        chk("R9 missed untouched", longint'(missed_count), longint'(exp_miss));
        cfg_inf_num = 1'b1;
        cyc(1, 64, 1, 0, 1, 1, 0, "R9 limit lifted");
        cyc(1, 65, 0, 0, 1, 0, 1, "R9 end2");
        seg_end_chk("R9 seg2", 2);
    endtask

    task automatic t_inf_len;
        cfg_mode = 2'd1; cfg_seg_len = 2; cfg_inf_len = 1'b1;
        cyc(1, 70, 1, 0, 1, 1, 0, "R10 open");
        for (int i = 1; i < 5; i++) cyc(1, 70 + i, 0, 0, 1, 0, 0, "R10 no length end");
        cyc(1, 75, 0, 1, 1, 0, 1, "R10 stop ends");
        seg_end_chk("R10 seg", 6);
        cfg_inf_len = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_infinite();
        t_fixed();
        t_variable();
        t_stop();
        t_quota();
        t_inf_len();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule